// File: doc/BRIEF.md
# Late-Binding Register Rename Unit

This unit renames one instruction per cycle for an out-of-order core that defers physical register allocation until results exist. At decode, each logical destination is bound only to a virtual tag drawn from a free pool. A physical register is taken from a second pool when the producing instruction completes. Each logical source is therefore resolved to a physical register number if that register's current virtual tag has already been bound, and to the virtual tag itself otherwise.

Two tables hold the state. The logical map has one entry per logical register: the newest virtual tag, the physical number last bound to it, and a bound flag. The tag map has one entry per virtual tag: the physical register bound to that tag and a flag saying whether a binding exists. A rollback port rewrites one logical map entry to an earlier tag, for example a displaced tag recovered from the reorder buffer. Both pools start with the lowest indices (one per logical register) in use, so that logical register L begins mapped to tag L and physical register L. No free port exists, so tags and physical registers are only consumed until the next reset.

Top module: `vpr_rename`

## Requirements
- R1: After reset, every logical register L resolves to physical register L with the physical flag set.
- R2: Each source output shows the stored physical number with the physical flag set (1) when its logical map entry is bound. Otherwise it shows the stored virtual tag with the flag clear (0). The lookup uses the state as it stood before this cycle's updates.
- R3: An accepted rename gives the destination the lowest-numbered free virtual tag on `dst_vp`. From the next cycle, that logical register resolves to this tag and is unbound.
- R4: An accepted rename outputs on `prev_vp` the virtual tag that the destination held before this rename.
- R5: An instruction whose source and destination are the same logical register reads the mapping that was in place before its own rename.
- R6: An accepted completion is given the lowest-numbered free physical register on `cmp_preg` and binds it to the completing tag. The logical map entry of `cmp_ldst` becomes bound to that register only if its current tag equals `cmp_vp`.
- R7: When a rename and a completion address the same logical entry in one cycle, the entry takes the new tag unbound, while the completing tag still receives its physical binding.
- R8: `ren_ready` is low whenever no virtual tag is free. A rename offered while it is low changes no mapping.
- R9: `cmp_ready` is low whenever no physical register is free. A completion offered while it is low changes no mapping.
- R10: Rollback sets the entry of `rb_lreg` to `rb_vp`, bound to that tag's recorded physical register if the tag has a binding and unbound otherwise. `ren_ready` is low in any cycle in which `rb_valid` is high.
- R11: If a completion of `rb_vp` is accepted in the same cycle as the rollback, the restored entry is bound to the physical register allocated by that completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Instruction offered for renaming |
| ren_ready | output | 1 | Rename accepted this cycle if valid |
| ren_src0 | input | LW | First logical source |
| ren_src1 | input | LW | Second logical source |
| ren_dst | input | LW | Logical destination |
| src0_tag | output | TW | Renamed first source (physical number or virtual tag) |
| src0_is_phys | output | 1 | 1 when src0_tag is a physical number |
| src1_tag | output | TW | Renamed second source |
| src1_is_phys | output | 1 | 1 when src1_tag is a physical number |
| dst_vp | output | VW | New virtual tag for the destination |
| prev_vp | output | VW | Tag displaced from the destination |
| cmp_valid | input | 1 | Completion offered |
| cmp_ready | output | 1 | Completion accepted this cycle if valid |
| cmp_vp | input | VW | Virtual tag of the completing instruction |
| cmp_ldst | input | LW | Logical destination of the completing instruction |
| cmp_preg | output | PW | Physical register allocated to the completion |
| rb_valid | input | 1 | Rollback request |
| rb_lreg | input | LW | Logical register to restore |
| rb_vp | input | VW | Earlier virtual tag to restore |

## Verification
Directed sequences cover four cases. The first is a rename whose source equals its destination, which separates pre-update lookup from post-update lookup. The second is a same-cycle rename and completion on one entry, which shows whether the rename takes priority. The third is a completion whose tag has already been overwritten, which shows whether the tag comparison is enforced. The fourth is a rollback that coincides with the completion of the restored tag, which shows whether the restore reads the new binding or the stale tag map. Seeded random traffic then mixes renames, completions of pending tags and occasional rollbacks until both pools run dry. This checks every output against a bench-side model of both tables and exercises the stall paths, whose missing state change shows up in later lookups.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
    localparam int LREG_DEF = 8;
    localparam int VP_DEF   = 24;
    localparam int PREG_DEF = 20;

    typedef enum logic {
        SRC_VTAG = 1'b0,
        SRC_PHYS = 1'b1
    } src_kind_e;
endpackage

// File: rtl/vpr_free_pool.sv
module vpr_free_pool #(
    parameter int N        = 24,
    parameter int RESERVED = 8,
    localparam int IW      = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    output logic          avail,
    output logic [IW-1:0] idx
);
    logic [N-1:0] free_d, free_q;

    always_comb begin
        avail  = |free_q;
        idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_q[i]) idx = IW'(i);
        end
        free_d = free_q;
        if (take && avail) free_d[idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= {N{1'b1}} << RESERVED;
        else        free_q <= free_d;
    end
endmodule

// File: rtl/vpr_src_lookup.sv
module vpr_src_lookup #(
    parameter int VW = 5,
    parameter int PW = 5,
    parameter int TW = 5
) (
    input  logic          bound,
    input  logic [VW-1:0] vtag,
    input  logic [PW-1:0] preg,
    output logic [TW-1:0] tag,
    output logic          is_phys
);
    vpr_pkg::src_kind_e kind;

    always_comb begin
        kind    = bound ? vpr_pkg::SRC_PHYS : vpr_pkg::SRC_VTAG;
        is_phys = (kind == vpr_pkg::SRC_PHYS);
        tag     = is_phys ? TW'(preg) : TW'(vtag);
    end
endmodule

// File: rtl/vpr_rename.sv
module vpr_rename #(
    parameter int NUM_LREG = vpr_pkg::LREG_DEF,
    parameter int NUM_VP   = vpr_pkg::VP_DEF,
    parameter int NUM_PREG = vpr_pkg::PREG_DEF,
    localparam int LW      = $clog2(NUM_LREG),
    localparam int VW      = $clog2(NUM_VP),
    localparam int PW      = $clog2(NUM_PREG),
    localparam int TW      = (VW > PW) ? VW : PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    output logic          ren_ready,
    input  logic [LW-1:0] ren_src0,
    input  logic [LW-1:0] ren_src1,
    input  logic [LW-1:0] ren_dst,
    output logic [TW-1:0] src0_tag,
    output logic          src0_is_phys,
    output logic [TW-1:0] src1_tag,
    output logic          src1_is_phys,
    output logic [VW-1:0] dst_vp,
    output logic [VW-1:0] prev_vp,
    input  logic          cmp_valid,
    output logic          cmp_ready,
    input  logic [VW-1:0] cmp_vp,
    input  logic [LW-1:0] cmp_ldst,
    output logic [PW-1:0] cmp_preg,
    input  logic          rb_valid,
    input  logic [LW-1:0] rb_lreg,
    input  logic [VW-1:0] rb_vp
);
    localparam int NSRC = 2;

    typedef struct packed {
        logic [VW-1:0] vtag;
        logic [PW-1:0] preg;
        logic          bound;
    } lmap_t;

    typedef struct packed {
        logic [PW-1:0] preg;
        logic          bound;
    } tmap_t;

    typedef struct packed {
        lmap_t [NUM_LREG-1:0] lmap;
        tmap_t [NUM_VP-1:0]   tmap;
    } state_t;

    state_t st_d, st_q;

    logic          vp_avail, pr_avail;
    logic [VW-1:0] vp_idx;
    logic [PW-1:0] pr_idx;
    logic          ren_fire, cmp_fire;

    assign ren_ready = vp_avail && !rb_valid;
    assign ren_fire  = ren_valid && ren_ready;
    assign cmp_ready = pr_avail;
    assign cmp_fire  = cmp_valid && cmp_ready;
    assign dst_vp    = vp_idx;
    assign cmp_preg  = pr_idx;
    assign prev_vp   = st_q.lmap[ren_dst].vtag;

    vpr_free_pool #(.N(NUM_VP), .RESERVED(NUM_LREG)) u_vp_pool (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (ren_fire),
        .avail (vp_avail),
        .idx   (vp_idx)
    );

    vpr_free_pool #(.N(NUM_PREG), .RESERVED(NUM_LREG)) u_pr_pool (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (cmp_fire),
        .avail (pr_avail),
        .idx   (pr_idx)
    );

    logic [LW-1:0] src_l   [NSRC];
    logic [TW-1:0] src_t   [NSRC];
    logic          src_p   [NSRC];

    assign src_l[0] = ren_src0;
    assign src_l[1] = ren_src1;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        vpr_src_lookup #(.VW(VW), .PW(PW), .TW(TW)) u_lookup (
            .bound   (st_q.lmap[src_l[g]].bound),
            .vtag    (st_q.lmap[src_l[g]].vtag),
            .preg    (st_q.lmap[src_l[g]].preg),
            .tag     (src_t[g]),
            .is_phys (src_p[g])
        );
    end

    assign src0_tag     = src_t[0];
    assign src0_is_phys = src_p[0];
    assign src1_tag     = src_t[1];
    assign src1_is_phys = src_p[1];

    // Write order encodes priority: completion, then rollback, then rename.
    always_comb begin
        st_d = st_q;

        if (cmp_fire) begin
            st_d.tmap[cmp_vp].preg  = pr_idx;
            st_d.tmap[cmp_vp].bound = 1'b1;
            if (st_q.lmap[cmp_ldst].vtag == cmp_vp) begin
                st_d.lmap[cmp_ldst].preg  = pr_idx;
                st_d.lmap[cmp_ldst].bound = 1'b1;
            end
        end

        if (rb_valid) begin
            st_d.lmap[rb_lreg].vtag = rb_vp;
            if (cmp_fire && (cmp_vp == rb_vp)) begin
                st_d.lmap[rb_lreg].preg  = pr_idx;
                st_d.lmap[rb_lreg].bound = 1'b1;
            end else begin
                st_d.lmap[rb_lreg].preg  = st_q.tmap[rb_vp].preg;
                st_d.lmap[rb_lreg].bound = st_q.tmap[rb_vp].bound;
            end
        end

        if (ren_fire) begin
            st_d.lmap[ren_dst].vtag  = vp_idx;
            st_d.lmap[ren_dst].preg  = '0;
            st_d.lmap[ren_dst].bound = 1'b0;
            st_d.tmap[vp_idx].bound  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LREG; i++) begin
                st_q.lmap[i].vtag  <= VW'(i);
                st_q.lmap[i].preg  <= PW'(i);
                st_q.lmap[i].bound <= 1'b1;
            end
            for (int j = 0; j < NUM_VP; j++) begin
                st_q.tmap[j].preg  <= (j < NUM_LREG) ? PW'(j) : '0;
                st_q.tmap[j].bound <= (j < NUM_LREG);
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/vpr_rename_sva.sv
module vpr_rename_sva #(
    parameter int NUM_PREG = 20,
    parameter int VW       = 5,
    parameter int PW       = 5,
    parameter int TW       = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ren_valid,
    input logic          ren_ready,
    input logic [VW-1:0] dst_vp,
    input logic [VW-1:0] prev_vp,
    input logic          cmp_valid,
    input logic          cmp_ready,
    input logic [PW-1:0] cmp_preg,
    input logic          rb_valid,
    input logic          src0_is_phys,
    input logic [TW-1:0] src0_tag
);
    p_fresh_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready) |-> (dst_vp != prev_vp));

    p_distinct_tags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && $past(ren_valid && ren_ready)) |-> (dst_vp != $past(dst_vp)));

    p_distinct_pregs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_ready && $past(cmp_valid && cmp_ready)) |-> (cmp_preg != $past(cmp_preg)));

    p_tag_pool_dry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_ready && !rb_valid) |=> !ren_ready);

    p_preg_pool_dry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_ready |=> !cmp_ready);

    p_rollback_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> !ren_ready);

    p_phys_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src0_is_phys |-> (src0_tag < TW'(NUM_PREG)));
endmodule

bind vpr_rename vpr_rename_sva #(
    .NUM_PREG (NUM_PREG),
    .VW       (VW),
    .PW       (PW),
    .TW       (TW)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_valid    (ren_valid),
    .ren_ready    (ren_ready),
    .dst_vp       (dst_vp),
    .prev_vp      (prev_vp),
    .cmp_valid    (cmp_valid),
    .cmp_ready    (cmp_ready),
    .cmp_preg     (cmp_preg),
    .rb_valid     (rb_valid),
    .src0_is_phys (src0_is_phys),
    .src0_tag     (src0_tag)
);

// File: tb/vpr_rename_tb.sv
module vpr_rename_tb;
    localparam int CLK_P = 10;
    localparam int NL = 8;
    localparam int NV = 24;
    localparam int NP = 20;
    localparam int LW = 3;
    localparam int VW = 5;
    localparam int PW = 5;
    localparam int TW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ren_valid = 1'b0;
    logic [LW-1:0] ren_src0 = '0, ren_src1 = '0, ren_dst = '0;
    logic cmp_valid = 1'b0;
    logic [VW-1:0] cmp_vp = '0;
    logic [LW-1:0] cmp_ldst = '0;
    logic rb_valid = 1'b0;
    logic [LW-1:0] rb_lreg = '0;
    logic [VW-1:0] rb_vp = '0;
    logic ren_ready, src0_is_phys, src1_is_phys, cmp_ready;
    logic [TW-1:0] src0_tag, src1_tag;
    logic [VW-1:0] dst_vp, prev_vp;
    logic [PW-1:0] cmp_preg;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string ovr = "";

    int gvp[NL], gp[NL];
    bit gv[NL];
    int pp[NV];
    bit pb[NV];
    bit vfree[NV], pend[NV];
    int ldst_of[NV];
    bit pfree[NP];

    always #(CLK_P/2) clk = ~clk;

    vpr_rename u_dut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_ready(ren_ready),
        .ren_src0(ren_src0), .ren_src1(ren_src1), .ren_dst(ren_dst),
        .src0_tag(src0_tag), .src0_is_phys(src0_is_phys),
        .src1_tag(src1_tag), .src1_is_phys(src1_is_phys),
        .dst_vp(dst_vp), .prev_vp(prev_vp),
        .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
        .cmp_vp(cmp_vp), .cmp_ldst(cmp_ldst), .cmp_preg(cmp_preg),
        .rb_valid(rb_valid), .rb_lreg(rb_lreg), .rb_vp(rb_vp)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int low_vp();
        for (int i = 0; i < NV; i++) if (vfree[i]) return i;
        return -1;
    endfunction

    function automatic int low_p();
        for (int i = 0; i < NP; i++) if (pfree[i]) return i;
        return -1;
    endfunction

    task automatic idle();
        ren_valid = 0; cmp_valid = 0; rb_valid = 0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < NL; i++) begin gvp[i] = i; gp[i] = i; gv[i] = 1; end
        for (int j = 0; j < NV; j++) begin
            pp[j] = (j < NL) ? j : 0; pb[j] = (j < NL);
            vfree[j] = (j >= NL); pend[j] = 0; ldst_of[j] = 0;
        end
        for (int k = 0; k < NP; k++) pfree[k] = (k >= NL);
    endtask

    task automatic src_chk(int s, int act_t, int act_p, bit fire);
        string lbl;
        lbl = (ovr != "") ? ovr : ((fire && s == int'(ren_dst)) ? "R5" : "R2");
        chk(lbl, act_p, int'(gv[s]));
        chk(lbl, act_t, gv[s] ? gp[s] : gvp[s]);
    endtask

    // Called at a falling edge with inputs set; checks, updates model, waits a cycle.
    task automatic cycle();
        int nv, np, s0, s1, d, cv, cl, rl, rv;
        bit rr, rf, cr, cf;
        int ogvp[NL];
        int opp[NV];
        bit opb[NV];
        #1;
        nv = low_vp(); np = low_p();
        rr = (nv >= 0) && !rb_valid; rf = ren_valid && rr;
        cr = (np >= 0); cf = cmp_valid && cr;
        s0 = int'(ren_src0); s1 = int'(ren_src1); d = int'(ren_dst);
        cv = int'(cmp_vp); cl = int'(cmp_ldst); rl = int'(rb_lreg); rv = int'(rb_vp);
        chk(rb_valid ? "R10" : "R8", int'(ren_ready), int'(rr));
        chk("R9", int'(cmp_ready), int'(cr));
        src_chk(s0, int'(src0_tag), int'(src0_is_phys), rf);
        src_chk(s1, int'(src1_tag), int'(src1_is_phys), rf);
        if (rf) begin
            chk("R3", int'(dst_vp), nv);
            chk("R4", int'(prev_vp), gvp[d]);
        end
        if (cf) chk("R6", int'(cmp_preg), np);
        ogvp = gvp; opp = pp; opb = pb;
        if (cf) begin
            pp[cv] = np; pb[cv] = 1; pfree[np] = 0; pend[cv] = 0;
            if (ogvp[cl] == cv) begin gp[cl] = np; gv[cl] = 1; end
        end
        if (rb_valid) begin
            gvp[rl] = rv;
            if (cf && cv == rv) begin gp[rl] = np; gv[rl] = 1; end
            else begin gp[rl] = opp[rv]; gv[rl] = opb[rv]; end
        end
        if (rf) begin
            gvp[d] = nv; gp[d] = 0; gv[d] = 0; pb[nv] = 0;
            vfree[nv] = 0; pend[nv] = 1; ldst_of[nv] = d;
        end
        @(negedge clk);
    endtask

    task automatic ren(int s0, int s1, int d);
        ren_valid = 1; ren_src0 = LW'(s0); ren_src1 = LW'(s1); ren_dst = LW'(d);
    endtask

    task automatic read(int s, string lbl);
        idle(); ren_src0 = LW'(s); ren_src1 = LW'(s); ovr = lbl;
        cycle();
        ovr = "";
    endtask

    task automatic random_phase(int n);
        for (int c = 0; c < n; c++) begin
            idle();
            ren_src0 = LW'($urandom % NL); ren_src1 = LW'($urandom % NL);
            ren_dst = LW'($urandom % NL);
            ren_valid = ($urandom % 4) != 0;
            begin
                int st;
                st = $urandom % NV;
                for (int k = 0; k < NV; k++) begin
                    int t;
                    t = (st + k) % NV;
                    if (pend[t] && !cmp_valid && ($urandom % 2 == 0)) begin
                        cmp_valid = 1; cmp_vp = VW'(t); cmp_ldst = LW'(ldst_of[t]);
                    end
                end
            end
            if ($urandom % 10 == 0) begin
                int r;
                rb_valid = 1; rb_lreg = LW'($urandom % NL); rb_vp = VW'(rb_lreg);
                for (int k = 0; k < 8; k++) begin
                    r = $urandom % NV;
                    if (!vfree[r]) rb_vp = VW'(r);
                end
            end
            cycle();
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();
        for (int l = 0; l < NL; l++) begin
            idle(); ren_src0 = LW'(l); ren_src1 = LW'(NL - 1 - l); ovr = "R1";
            cycle();
        end
        ovr = "";
        // same register read and written (R5), tag 8 expected
        idle(); ren(3, 3, 3); cycle();
        read(3, "R3");
        // rename and completion hit entry 3 together (R7)
        idle(); ren(0, 1, 3); cmp_valid = 1; cmp_vp = 5'd8; cmp_ldst = 3'd3; cycle();
        read(3, "R7");
        // rollback to bound tag while rename is offered (R10)
        idle(); ren(0, 0, 1); rb_valid = 1; rb_lreg = 3'd3; rb_vp = 5'd8; cycle();
        read(3, "R10");
        // rollback concurrent with completion of the restored tag (R11)
        idle(); ren(0, 0, 5); cycle();
        idle(); rb_valid = 1; rb_lreg = 3'd2; rb_vp = 5'd10;
        cmp_valid = 1; cmp_vp = 5'd10; cmp_ldst = 3'd5; cycle();
        read(2, "R11");
        read(5, "R6");
        // stale completion: tag overwritten before it completes (R6)
        idle(); ren(0, 0, 6); cycle();
        idle(); ren(0, 0, 6); cycle();
        idle(); cmp_valid = 1; cmp_vp = 5'd11; cmp_ldst = 3'd6; cycle();
        read(6, "R6");
        random_phase(90);
        for (int e = 0; e < 4; e++) begin
            do_reset();
            random_phase(90);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule